// File: doc/BRIEF.md
# Per-Slot Interrupt Accumulator

This block gathers interrupt sources from a set of peripheral slots. Each slot is addressed by an 8-bit index and has eight source lines. A pulse on a source line sets the matching bit of that slot's pending register, and the bit stays set until software writes a one to it at the slot's clear address. Each slot also has an enable bit and a 3-bit owner value, which is an input to the block and names the execution environment that services the slot.

Above the pending registers sits a summary level, with one bit per slot packed into 32-bit words. The summary bit of a slot is set when the slot is enabled, is owned by the environment being read, and has any pending bit set. Software scans the summary words to find which slots need service, then reads the pending register of each slot it found.

A single interrupt output, driven from a register, is high while any enabled slot owned by the selected environment has pending bits. Register reads return data one cycle after the address is presented.

Top module: `irq_acc_top`

## Requirements
- R1: After reset, every pending register and every enable bit is zero, and both `irq_o` and `reg_rdata_o` are low.
- R2: A pulse on source bit j of slot s sets bit j of the pending register of s at the next clock edge. Pulses are OR-ed into the register. The register reads at byte address 0x600 + 4*s in bits [7:0], with bits [31:8] read as zero.
- R3: A write to byte address 0xA00 + 4*s clears every pending bit of s whose write-data bit is 1 and leaves the bits written as 0 unchanged. Reads of the clear addresses return zero.
- R4: When a source pulse and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R5: The enable bit of slot s is write-data bit 0 at byte address 0x200 + 4*s. It reads back in bit 0, with all other bits read as zero.
- R6: The summary word for environment M (0..5) and word N (0..7) is at byte address 32*M + 4*N. Its bit b is 1 exactly when slot 32*N + b is enabled, has owner M, and has a non-zero pending register.
- R7: Summary words for an environment number of NUM_ENV or above (M = 6 or 7) read as zero, even if a slot carries that owner value.
- R8: `irq_o` goes high one clock after the registers show an enabled, pending slot whose owner equals `irq_env_i`, and goes low one clock after the last such slot stops qualifying. Slots with other owners do not affect it.
- R9: Pending bits are latched whether or not the slot is enabled. A disabled slot with pending bits raises neither its summary bit nor `irq_o`.
- R10: Writes to status or summary addresses change nothing. Addresses outside the four regions read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_pulse_i | input | NUM_SLOTS*SRC_W | Source pulses; slot s uses bits [s*SRC_W +: SRC_W] |
| slot_owner_i | input | NUM_SLOTS*OWN_W | Owner of each slot; slot s uses bits [s*OWN_W +: OWN_W] |
| irq_env_i | input | OWN_W | Environment whose slots drive `irq_o` |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte address for reads and writes |
| reg_wdata_i | input | SRC_W | Write data (clear mask, or enable in bit 0) |
| reg_rdata_o | output | 32 | Read data, registered, one cycle after the address |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The two functions that can fall in the same cycle are setting a pending bit from a source pulse and clearing it through a write-one-to-clear access. The bench drives a pulse and a clear write to the same slot in one cycle, first on the same bit and then on different bits. It then reads the pending register back and expects the pulsed bit to be set and only the other written bits to be cleared. The cycles in which the interrupt output rises and falls around such clears are also sampled, so that the one-cycle registered latency is checked on both edges.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;

    localparam int ADDR_W = 12;
    localparam int RDATA_W = 32;
    localparam int SLOT_IDX_W = 8;
    localparam int ENV_IDX_W = 3;
    localparam int WORD_IDX_W = 3;
    localparam int SUM_WORD_W = 32;

    // Region boundaries in bytes. The enable, status and clear regions each
    // span 1 KiB and start 0x200 past a 1 KiB boundary, so the slot index is
    // the same address slice minus one constant bias in all three regions.
    localparam logic [ADDR_W-1:0] SUM_END  = 12'h100;
    localparam logic [ADDR_W-1:0] EN_BASE  = 12'h200;
    localparam logic [ADDR_W-1:0] STS_BASE = 12'h600;
    localparam logic [ADDR_W-1:0] CLR_BASE = 12'hA00;
    localparam logic [ADDR_W-1:0] CLR_END  = 12'hE00;
    localparam logic [SLOT_IDX_W-1:0] SLOT_BIAS = 8'h80;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_SUMMARY,
        RGN_ENABLE,
        RGN_STATUS,
        RGN_CLEAR
    } region_e;

    typedef struct packed {
        region_e                region;
        logic [SLOT_IDX_W-1:0]  slot;
        logic [ENV_IDX_W-1:0]   env;
        logic [WORD_IDX_W-1:0]  word;
    } acc_dec_t;

    function automatic acc_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        acc_dec_t r;
        r.region = RGN_NONE;
        r.slot   = a[9:2] - SLOT_BIAS;
        r.env    = a[7:5];
        r.word   = a[4:2];
        if (a < SUM_END) begin
            r.region = RGN_SUMMARY;
        end else if (a >= EN_BASE && a < STS_BASE) begin
            r.region = RGN_ENABLE;
        end else if (a >= STS_BASE && a < CLR_BASE) begin
            r.region = RGN_STATUS;
        end else if (a >= CLR_BASE && a < CLR_END) begin
            r.region = RGN_CLEAR;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_acc_slot_bank.sv
module irq_acc_slot_bank #(
    parameter int NUM_SLOTS = 256,
    parameter int SRC_W = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_SLOTS-1:0][SRC_W-1:0]  src_i,
    input  logic                             en_wr_i,
    input  logic                             en_val_i,
    input  logic                             clr_wr_i,
    input  logic [SRC_W-1:0]                 clr_mask_i,
    input  logic [SLOT_W-1:0]                wr_slot_i,
    output logic [NUM_SLOTS-1:0][SRC_W-1:0]  pend_o,
    output logic [NUM_SLOTS-1:0]             en_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][SRC_W-1:0] pend;
        logic [NUM_SLOTS-1:0]            en;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            logic [SRC_W-1:0] clr_d;
            clr_d = (clr_wr_i && wr_slot_i == SLOT_W'(s)) ? clr_mask_i : '0;
            // The source term is OR-ed in after the clear, so a set wins.
            st_d.pend[s] = (st_q.pend[s] & ~clr_d) | src_i[s];
        end
        if (en_wr_i) begin
            st_d.en[wr_slot_i] = en_val_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;

    p_set_latched_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pend_o & $past(src_i)) == $past(src_i)));

    p_pend_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_wr_i && src_i == '0) |=> $stable(pend_o));

    p_clear_applied_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_wr_i |=> ((pend_o[$past(wr_slot_i)] & $past(clr_mask_i)
                       & ~$past(src_i[wr_slot_i])) == '0));

    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_wr_i |=> ((pend_o[$past(wr_slot_i)] & $past(src_i[wr_slot_i]))
                      == $past(src_i[wr_slot_i])));

    p_enable_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_wr_i |=> (en_o[$past(wr_slot_i)] == $past(en_val_i)));

endmodule

// File: rtl/irq_acc_summary.sv
module irq_acc_summary #(
    parameter int NUM_SLOTS = 256,
    parameter int SRC_W = 8,
    parameter int NUM_ENV = 6,
    parameter int OWN_W = 3
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NUM_SLOTS-1:0][SRC_W-1:0]  pend_i,
    input  logic [NUM_SLOTS-1:0]             en_i,
    input  logic [NUM_SLOTS-1:0][OWN_W-1:0]  owner_i,
    input  logic [OWN_W-1:0]                 irq_env_i,
    output logic [NUM_ENV-1:0][NUM_SLOTS-1:0] sum_o,
    output logic                             irq_o
);

    typedef struct packed {
        logic irq;
    } irq_st_t;

    logic [NUM_SLOTS-1:0] active;
    logic [NUM_SLOTS-1:0] hit;
    irq_st_t st_d, st_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign active[s] = en_i[s] && (pend_i[s] != '0);
        assign hit[s]    = active[s] && (owner_i[s] == irq_env_i);
        for (genvar e = 0; e < NUM_ENV; e++) begin : g_env
            assign sum_o[e][s] = active[s] && (owner_i[s] == OWN_W'(e));
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.irq = |hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R8: a raised request must trace back to an enabled, pending slot.
    p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(|(en_i & active)));

    // R9: a request can never be raised while no slot is enabled.
    p_irq_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(en_i) == '0) |-> !irq_o);

endmodule

// File: rtl/irq_acc_readback.sv
module irq_acc_readback
    import irq_acc_pkg::*;
#(
    parameter int NUM_SLOTS = 256,
    parameter int SRC_W = 8,
    parameter int NUM_ENV = 6,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int WORDS = NUM_SLOTS / SUM_WORD_W
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  acc_dec_t                          dec_i,
    input  logic                              slot_ok_i,
    input  logic [NUM_SLOTS-1:0][SRC_W-1:0]   pend_i,
    input  logic [NUM_SLOTS-1:0]              en_i,
    input  logic [NUM_ENV-1:0][NUM_SLOTS-1:0] sum_i,
    output logic [RDATA_W-1:0]                rdata_o
);

    typedef struct packed {
        logic [RDATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic [SLOT_W-1:0] slot_idx;
    logic [SLOT_W-1:0] word_base;

    assign slot_idx  = dec_i.slot[SLOT_W-1:0];
    assign word_base = SLOT_W'({dec_i.word, 5'b0});

    always_comb begin
        st_d = st_q;
        st_d.rdata = '0;
        unique case (dec_i.region)
            RGN_SUMMARY: begin
                if (32'(dec_i.env) < NUM_ENV && 32'(dec_i.word) < WORDS) begin
                    st_d.rdata = sum_i[dec_i.env][word_base +: SUM_WORD_W];
                end
            end
            RGN_ENABLE: begin
                if (slot_ok_i) begin
                    st_d.rdata = RDATA_W'(en_i[slot_idx]);
                end
            end
            RGN_STATUS: begin
                if (slot_ok_i) begin
                    st_d.rdata = RDATA_W'(pend_i[slot_idx]);
                end
            end
            default: st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o = st_q.rdata;

    p_clear_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(dec_i.region) == RGN_CLEAR) |-> (rdata_o == '0));

    p_env_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(dec_i.region) == RGN_SUMMARY && 32'($past(dec_i.env)) >= NUM_ENV)
        |-> (rdata_o == '0));

    p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(dec_i.region) == RGN_NONE) |-> (rdata_o == '0));

    p_status_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(dec_i.region) == RGN_STATUS) |-> (rdata_o[RDATA_W-1:SRC_W] == '0));

endmodule

// File: rtl/irq_acc_top.sv
module irq_acc_top
    import irq_acc_pkg::*;
#(
    parameter int NUM_SLOTS = 256,
    parameter int SRC_W = 8,
    parameter int NUM_ENV = 6,
    parameter int OWN_W = 3
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [NUM_SLOTS*SRC_W-1:0]   src_pulse_i,
    input  logic [NUM_SLOTS*OWN_W-1:0]   slot_owner_i,
    input  logic [OWN_W-1:0]             irq_env_i,
    input  logic                         reg_wr_i,
    input  logic [ADDR_W-1:0]            reg_addr_i,
    input  logic [SRC_W-1:0]             reg_wdata_i,
    output logic [RDATA_W-1:0]           reg_rdata_o,
    output logic                         irq_o
);

    localparam int SLOT_W = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS-1:0][SRC_W-1:0]   src_2d;
    logic [NUM_SLOTS-1:0][OWN_W-1:0]   owner_2d;
    logic [NUM_SLOTS-1:0][SRC_W-1:0]   pend;
    logic [NUM_SLOTS-1:0]              en;
    logic [NUM_ENV-1:0][NUM_SLOTS-1:0] sum;
    acc_dec_t                          dec;
    logic                              slot_ok;
    logic                              en_wr;
    logic                              clr_wr;

    assign src_2d   = src_pulse_i;
    assign owner_2d = slot_owner_i;
    assign dec      = decode_addr(reg_addr_i);
    assign slot_ok  = 32'(dec.slot) < NUM_SLOTS;
    assign en_wr    = reg_wr_i && slot_ok && dec.region == RGN_ENABLE;
    assign clr_wr   = reg_wr_i && slot_ok && dec.region == RGN_CLEAR;

    irq_acc_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .SRC_W     (SRC_W)
    ) bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_i      (src_2d),
        .en_wr_i    (en_wr),
        .en_val_i   (reg_wdata_i[0]),
        .clr_wr_i   (clr_wr),
        .clr_mask_i (reg_wdata_i),
        .wr_slot_i  (dec.slot[SLOT_W-1:0]),
        .pend_o     (pend),
        .en_o       (en)
    );

    irq_acc_summary #(
        .NUM_SLOTS (NUM_SLOTS),
        .SRC_W     (SRC_W),
        .NUM_ENV   (NUM_ENV),
        .OWN_W     (OWN_W)
    ) summary_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pend_i    (pend),
        .en_i      (en),
        .owner_i   (owner_2d),
        .irq_env_i (irq_env_i),
        .sum_o     (sum),
        .irq_o     (irq_o)
    );

    irq_acc_readback #(
        .NUM_SLOTS (NUM_SLOTS),
        .SRC_W     (SRC_W),
        .NUM_ENV   (NUM_ENV)
    ) readback_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .dec_i     (dec),
        .slot_ok_i (slot_ok),
        .pend_i    (pend),
        .en_i      (en),
        .sum_i     (sum),
        .rdata_o   (reg_rdata_o)
    );

    // R10: a write that hits neither the enable nor the clear region leaves
    // all slot state untouched unless a source pulse arrives.
    p_stray_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && !en_wr && !clr_wr && src_pulse_i == '0)
        |=> ($stable(pend) && $stable(en)));

endmodule

// File: tb/irq_acc_top_tb_top.sv
`timescale 1ns/1ps
module irq_acc_top_tb_top;

    localparam int NUM_SLOTS = 256;
    localparam int SRC_W = 8;
    localparam int NUM_ENV = 6;
    localparam int OWN_W = 3;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_PULSE = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [11:0] addr;   // byte address, or slot number for a pulse
        logic [7:0]  data;
        logic [31:0] exp;
        logic [3:0]  req;
    } step_t;

    // Slot 38: owner 2, summary word 1 bit 6. Slot 255: owner 3, word 7 bit 31.
    localparam int NSTEPS = 23;
    localparam step_t STEPS [NSTEPS] = '{
        '{OP_PULSE, 12'd38,  8'h05, 32'h0,        4'd2},
        '{OP_RD,    12'h698, 8'h00, 32'h05,       4'd2},   // R2 latch
        '{OP_PULSE, 12'd38,  8'h80, 32'h0,        4'd2},
        '{OP_RD,    12'h698, 8'h00, 32'h85,       4'd2},   // R2 OR-in
        '{OP_RD,    12'h044, 8'h00, 32'h0,        4'd9},   // R9 disabled
        '{OP_WR,    12'h298, 8'hFF, 32'h0,        4'd5},
        '{OP_RD,    12'h298, 8'h00, 32'h1,        4'd5},   // R5 bit 0 only
        '{OP_RD,    12'h044, 8'h00, 32'h40,       4'd6},   // R6 summary set
        '{OP_RD,    12'h084, 8'h00, 32'h0,        4'd6},   // R6 other owner
        '{OP_WR,    12'hA98, 8'h04, 32'h0,        4'd3},
        '{OP_RD,    12'h698, 8'h00, 32'h81,       4'd3},   // R3 partial clear
        '{OP_RD,    12'hA98, 8'h00, 32'h0,        4'd3},   // R3 clear reads 0
        '{OP_WR,    12'h698, 8'hFF, 32'h0,        4'd10},
        '{OP_RD,    12'h698, 8'h00, 32'h81,       4'd10},  // R10 status write
        '{OP_WR,    12'hA98, 8'hFF, 32'h0,        4'd3},
        '{OP_RD,    12'h698, 8'h00, 32'h0,        4'd3},   // R3 full clear
        '{OP_RD,    12'h044, 8'h00, 32'h0,        4'd6},   // R6 empty slot
        '{OP_PULSE, 12'd255, 8'h01, 32'h0,        4'd2},
        '{OP_WR,    12'h5FC, 8'h01, 32'h0,        4'd5},
        '{OP_RD,    12'h07C, 8'h00, 32'h80000000, 4'd6},   // R6 top slot
        '{OP_WR,    12'hDFC, 8'h01, 32'h0,        4'd3},
        '{OP_RD,    12'h9FC, 8'h00, 32'h0,        4'd3},   // R3 top slot
        '{OP_RD,    12'hE00, 8'h00, 32'h0,        4'd10}   // R10 unmapped
    };

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic [NUM_SLOTS*SRC_W-1:0]    src = '0;
    logic [NUM_SLOTS*OWN_W-1:0]    owner = '0;
    logic [OWN_W-1:0]              irq_env = 3'd2;
    logic                          wr = 1'b0;
    logic [11:0]                   addr = '0;
    logic [SRC_W-1:0]              wdata = '0;
    logic [31:0]                   rdata;
    logic                          irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    irq_acc_top #(
        .NUM_SLOTS (NUM_SLOTS),
        .SRC_W     (SRC_W),
        .NUM_ENV   (NUM_ENV),
        .OWN_W     (OWN_W)
    ) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .src_pulse_i  (src),
        .slot_owner_i (owner),
        .irq_env_i    (irq_env),
        .reg_wr_i     (wr),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_o        (irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog R1 got cycles=%0d exp finish earlier", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        @(posedge clk);
        @(negedge clk);
        v = rdata;
    endtask

    task automatic do_pulse(input int slot, input logic [7:0] bits);
        @(negedge clk);
        src[slot*SRC_W +: SRC_W] = bits;
        @(posedge clk);
        @(negedge clk);
        src = '0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        for (int s = 0; s < NUM_SLOTS; s++) owner[s*OWN_W +: OWN_W] = OWN_W'(s % NUM_ENV);
        wait_edges(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 rdata after reset", rdata, 32'h0);
        do_read(12'h600, v); check("R1 pending slot0", v, 32'h0);
        do_read(12'h200, v); check("R1 enable slot0", v, 32'h0);

        // Table walk
        for (int i = 0; i < NSTEPS; i++) begin
            step_t st;
            st = STEPS[i];
            if (st.op == OP_WR) begin
                do_write(st.addr, st.data);
            end else if (st.op == OP_PULSE) begin
                do_pulse(int'(st.addr), st.data);
            end else begin
                do_read(st.addr, v);
                check($sformatf("R%0d step %0d", st.req, i), v, st.exp);
            end
        end

        // R4: pulse and clear on the same bit in the same cycle
        @(negedge clk);
        src[38*SRC_W +: SRC_W] = 8'h02;
        wr = 1'b1; addr = 12'hA98; wdata = 8'h02;
        @(posedge clk); @(negedge clk);
        src = '0; wr = 1'b0;
        do_read(12'h698, v); check("R4 same-bit set wins", v, 32'h02);

        // R4: pulse one bit while clearing another
        @(negedge clk);
        src[38*SRC_W +: SRC_W] = 8'h01;
        wr = 1'b1; addr = 12'hA98; wdata = 8'h02;
        @(posedge clk); @(negedge clk);
        src = '0; wr = 1'b0;
        do_read(12'h698, v); check("R4 set one clear other", v, 32'h01);
        check("R8 irq for owned pending slot", 32'(irq), 32'h1);

        // R8: fall latency after clear
        do_write(12'hA98, 8'hFF);
        check("R8 irq still high one cycle", 32'(irq), 32'h1);
        wait_edges(1);
        check("R8 irq low after clear", 32'(irq), 32'h0);

        // R8: rise latency after pulse
        do_pulse(38, 8'h10);
        check("R8 irq not yet high", 32'(irq), 32'h0);
        wait_edges(1);
        check("R8 irq high after pulse", 32'(irq), 32'h1);

        // R9: disabling drops the request but keeps pending
        do_write(12'h298, 8'h00);
        wait_edges(1);
        check("R9 irq low when disabled", 32'(irq), 32'h0);
        do_pulse(38, 8'h20);
        do_read(12'h698, v); check("R9 pending latched while disabled", v, 32'h30);
        wait_edges(1);
        check("R9 irq stays low", 32'(irq), 32'h0);

        // R8: other owner does not raise the request, then env switch does
        do_pulse(40, 8'h01);
        do_write(12'h2A0, 8'h01);
        wait_edges(2);
        check("R8 other-owner slot ignored", 32'(irq), 32'h0);
        @(negedge clk); irq_env = 3'd4;
        wait_edges(1);
        check("R8 irq follows selected env", 32'(irq), 32'h1);

        // R7: owner value beyond the environment count
        @(negedge clk); owner[1*OWN_W +: OWN_W] = 3'd6; irq_env = 3'd6;
        do_pulse(1, 8'h02);
        do_write(12'h204, 8'h01);
        do_read(12'h0C0, v); check("R7 env6 summary reads zero", v, 32'h0);
        do_read(12'h020, v); check("R7 env1 summary excludes slot1", v, 32'h0);
        do_read(12'h604, v); check("R2 slot1 pending", v, 32'h02);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule